// File: doc/BRIEF.md
# Parallel Camera Frame Capture Controller

This block sits behind an 8-bit parallel camera port. Each system clock cycle carries one camera byte together with the line and frame qualifiers (HSYNC and VSYNC). The block decides which frames and which bytes of a frame are kept. It packs the kept bytes into 32-bit words and offers them on a valid/ready output toward a memory-writing sink. Capture is started and stopped by one-cycle control pulses. Starting and stopping are aligned to frame boundaries: nothing is forwarded until a new frame begins, a one-shot mode stops by itself after one frame, and a stop request that arrives in the middle of a frame waits for that frame to finish.

A small state machine in `cap_frame_fsm` controls capture. It has three states. **ST_IDLE** means capture is off. **ST_ARMED** means capture is enabled and the block is waiting for a frame to start. **ST_CAPTURE** means a frame is being taken. Its transitions are:
- *arm*: ST_IDLE to ST_ARMED on a start pulse.
- *disarm*: ST_ARMED to ST_IDLE on a stop pulse.
- *sof*: ST_ARMED to ST_CAPTURE when VSYNC becomes active.
- *rearm*: ST_CAPTURE to ST_ARMED when VSYNC becomes inactive in continuous mode with no stop pending.
- *finish*: ST_CAPTURE to ST_IDLE when VSYNC becomes inactive in one-shot mode, or when a stop is pending.

Around the state machine are three other pieces: a polarity and edge stage, a crop window counter, and a byte-to-word packer with a single holding register.

In a compressed-stream (JPEG) mode, HSYNC only marks which bytes are valid, cropping is bypassed, and a partly filled last word is still sent out. An embedded-sync select is accepted only so that the block can check whether the configuration is legal and decide how the sync lines are read. The embedded sync codes themselves are not decoded.

Top module: `cam_capture_ctrl`

## Requirements
- R1: After reset, `cap_active`, `out_valid`, `frame_end` and `overrun` are all 0.
- R2: A `ctl_start` pulse enables capture and raises `cap_active`. No byte is forwarded until VSYNC goes from inactive to active. A frame that was already running when capture was enabled is skipped entirely.
- R3: Captured bytes are packed little-endian: the first byte of a word is in bits 7:0 and the fourth in bits 31:24. The word becomes valid on the cycle after its fourth byte.
- R4: With `cfg_snapshot`=1, exactly one frame is captured, and `cap_active` falls in the same cycle as the `frame_end` pulse of that frame. Later frames are not captured.
- R5: With `cfg_snapshot`=0, successive frames are captured. A `ctl_stop` pulse during a frame leaves `cap_active` at 1 and lets that frame finish in full. `cap_active` then drops together with that frame's `frame_end`.
- R6: A `ctl_stop` pulse while capture is waiting for a frame clears `cap_active` on the next cycle.
- R7: With crop on, a byte is kept only if its position x in the line lies in [`crop_x0`, `crop_x0`+`crop_xcnt`) and its line index y lies in [`crop_y0`, `crop_y0`+`crop_ycnt`). x counts from 0 at the first active byte of each line, and y counts from 0 at the first line of the frame. A window that reaches past the picture is clipped to the picture.
- R8: With `cfg_jpeg`=1, every byte with HSYNC active is kept and crop has no effect. A partial word left at frame end is sent with its unused upper bytes set to 0. With `cfg_jpeg`=0, a partial word at frame end is discarded, and the next frame starts a fresh word.
- R9: `cfg_hs_pol`/`cfg_vs_pol` set to 1 means the line is active high, and 0 means active low. When `cfg_embedded`=1, both polarity bits are ignored and the lines are read as active high.
- R10: `cfg_illegal` is 1 exactly when `cfg_embedded` and `cfg_jpeg` are both 1.
- R11: While `out_valid`=1 and `out_ready`=0, `out_data` holds its value. If a word completes while the holding register is still occupied and not being taken, that word is dropped and `overrun` is set. `overrun` stays set until the next `ctl_start`.
- R12: `frame_end` is a one-cycle pulse. It appears on the cycle after VSYNC becomes inactive at the end of a captured frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (one camera byte per cycle) |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_data | input | 8 | Camera byte |
| hsync_in | input | 1 | Line qualifier (data valid in JPEG mode) |
| vsync_in | input | 1 | Frame qualifier |
| ctl_start | input | 1 | Pulse: enable capture, clear overrun |
| ctl_stop | input | 1 | Pulse: request capture stop |
| cfg_snapshot | input | 1 | 1 = one-shot frame, 0 = continuous |
| cfg_jpeg | input | 1 | Compressed-stream mode |
| cfg_crop | input | 1 | Crop window enable |
| cfg_embedded | input | 1 | Embedded-sync select (legality and polarity only) |
| cfg_hs_pol | input | 1 | HSYNC active level |
| cfg_vs_pol | input | 1 | VSYNC active level |
| crop_x0 | input | X_W | First byte kept in a line |
| crop_xcnt | input | X_W | Bytes kept per line |
| crop_y0 | input | Y_W | First line kept |
| crop_ycnt | input | Y_W | Lines kept |
| out_data | output | OUT_W | Packed word |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Sink accepts word |
| cap_active | output | 1 | Capture enabled (armed or capturing) |
| frame_end | output | 1 | One-cycle end-of-captured-frame pulse |
| overrun | output | 1 | Sticky word-dropped flag |
| cfg_illegal | output | 1 | Embedded sync combined with JPEG mode |

## Verification
The packer is tried with whole lines of distinct byte values, so a wrong byte lane or byte order shows up in the compared words. It is also tried with lines whose length is not a multiple of four, which separates zero-filled flushing in JPEG mode from discarding and restarting in the other mode. Crop is tried with one window that lies inside the picture and one that overhangs it, which separates correct clipping from counters that run off the line or frame. Frame gating is tried with an enable that arrives in the middle of a frame, with a stop in the middle of a frame, with a stop while waiting for a frame, and with one-shot mode. Each of these pins down a different transition of the state machine. Inverted polarity, embedded select, and a stalled sink complete the patterns.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } cap_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic hs_pol,
    input  logic vs_pol,
    input  logic embedded,
    output logic hs_act,
    output logic vs_act,
    output logic hs_fall,
    output logic vs_rise,
    output logic vs_fall
);
    logic hs_prev, vs_prev;

    // R9: embedded select forces active-high reading
    assign hs_act = embedded ? hsync_in : (hs_pol ? hsync_in : ~hsync_in);
    assign vs_act = embedded ? vsync_in : (vs_pol ? vsync_in : ~vsync_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_prev <= 1'b0;
            vs_prev <= 1'b0;
        end else begin
            hs_prev <= hs_act;
            vs_prev <= vs_act;
        end
    end

    assign hs_fall = hs_prev & ~hs_act;
    assign vs_rise = vs_act & ~vs_prev;
    assign vs_fall = vs_prev & ~vs_act;
endmodule

// File: rtl/cap_frame_fsm.sv
module cap_frame_fsm
    import cam_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       snapshot,
    input  logic       vs_rise,
    input  logic       vs_fall,
    output cap_state_e state,
    output logic       frame_end,
    output logic       cap_active
);
    cap_state_e nxt;
    logic       stop_pend;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_ARMED;
            ST_ARMED: begin
                if (stop)         nxt = ST_IDLE;
                else if (vs_rise) nxt = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (vs_fall)
                    nxt = (snapshot || stop_pend || stop) ? ST_IDLE : ST_ARMED;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and deferred-stop memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_end  <= 1'b0;
            cap_active <= 1'b0;
            stop_pend  <= 1'b0;
        end else begin
            frame_end  <= (state == ST_CAPTURE) && vs_fall;
            cap_active <= (nxt != ST_IDLE);
            if (state == ST_CAPTURE && !vs_fall && stop) stop_pend <= 1'b1;
            else if (nxt != ST_CAPTURE)                  stop_pend <= 1'b0;
        end
    end

    p_arm_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !vs_rise && !stop) |=> (state == ST_ARMED));

    p_snap_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && vs_fall && snapshot) |=> (state == ST_IDLE && frame_end && !cap_active));

    p_defer_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && !vs_fall) |=> (state == ST_CAPTURE && cap_active));

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
endmodule

// File: rtl/cap_window.sv
module cap_window #(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hs_act,
    input  logic           vs_act,
    input  logic           hs_fall,
    input  logic           crop_on,
    input  logic [X_W-1:0] x0,
    input  logic [X_W-1:0] xcnt,
    input  logic [Y_W-1:0] y0,
    input  logic [Y_W-1:0] ycnt,
    output logic           in_win
);
    localparam logic [X_W-1:0] X_MAX = {X_W{1'b1}};
    localparam logic [Y_W-1:0] Y_MAX = {Y_W{1'b1}};

    logic [X_W-1:0] x_pos;
    logic [Y_W-1:0] y_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_pos <= '0;
            y_pos <= '0;
        end else begin
            if (!hs_act)                        x_pos <= '0;
            else if (vs_act && x_pos != X_MAX)  x_pos <= x_pos + 1'b1;
            if (!vs_act)                        y_pos <= '0;
            else if (hs_fall && y_pos != Y_MAX) y_pos <= y_pos + 1'b1;
        end
    end

    // R7: window compare with subtraction so the far edge cannot wrap
    always_comb begin
        in_win = 1'b1;
        if (crop_on)
            in_win = (x_pos >= x0) && ((x_pos - x0) < xcnt) &&
                     (y_pos >= y0) && ((y_pos - y0) < ycnt);
    end

    p_x_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_act |=> (x_pos == '0) || hs_act);
endmodule

// File: rtl/cap_packer.sv
module cap_packer #(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             flush,
    input  logic             drop,
    input  logic             clr_ovr,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             overrun
);
    localparam int LANES = OUT_W / 8;
    localparam int IDX_W = $clog2(LANES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

    logic [OUT_W-1:0] acc;
    logic [IDX_W-1:0] idx;
    logic [OUT_W-1:0] lane_val;
    logic             held;

    assign lane_val = OUT_W'(byte_in) << {idx, 3'b000};
    assign held     = out_valid && !out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            idx       <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (clr_ovr)                overrun   <= 1'b0;
            if (frame_start) begin
                acc <= '0;
                idx <= '0;
            end else if (byte_vld) begin
                if (idx == LAST) begin
                    if (held) overrun <= 1'b1;
                    else begin
                        out_data  <= acc | lane_val;
                        out_valid <= 1'b1;
                    end
                    acc <= '0;
                    idx <= '0;
                end else begin
                    acc <= acc | lane_val;
                    idx <= idx + 1'b1;
                end
            end else if (flush && idx != '0) begin
                if (held) overrun <= 1'b1;
                else begin
                    out_data  <= acc;
                    out_valid <= 1'b1;
                end
                acc <= '0;
                idx <= '0;
            end else if (drop) begin
                acc <= '0;
                idx <= '0;
            end
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun);
endmodule

// File: rtl/cam_capture_ctrl.sv
module cam_capture_ctrl
    import cam_cap_pkg::*;
#(
    parameter int X_W   = 12,
    parameter int Y_W   = 12,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       pix_data,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             ctl_start,
    input  logic             ctl_stop,
    input  logic             cfg_snapshot,
    input  logic             cfg_jpeg,
    input  logic             cfg_crop,
    input  logic             cfg_embedded,
    input  logic             cfg_hs_pol,
    input  logic             cfg_vs_pol,
    input  logic [X_W-1:0]   crop_x0,
    input  logic [X_W-1:0]   crop_xcnt,
    input  logic [Y_W-1:0]   crop_y0,
    input  logic [Y_W-1:0]   crop_ycnt,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             cap_active,
    output logic             frame_end,
    output logic             overrun,
    output logic             cfg_illegal
);
    logic       hs_act, vs_act, hs_fall, vs_rise, vs_fall;
    logic       in_win, byte_vld, fe_evt;
    cap_state_e state;

    assign cfg_illegal = cfg_embedded & cfg_jpeg;   // R10

    cap_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_pol(cfg_hs_pol), .vs_pol(cfg_vs_pol), .embedded(cfg_embedded),
        .hs_act(hs_act), .vs_act(vs_act), .hs_fall(hs_fall),
        .vs_rise(vs_rise), .vs_fall(vs_fall)
    );

    cap_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start(ctl_start), .stop(ctl_stop), .snapshot(cfg_snapshot),
        .vs_rise(vs_rise), .vs_fall(vs_fall),
        .state(state), .frame_end(frame_end), .cap_active(cap_active)
    );

    cap_window #(.X_W(X_W), .Y_W(Y_W)) u_win (
        .clk(clk), .rst_n(rst_n),
        .hs_act(hs_act), .vs_act(vs_act), .hs_fall(hs_fall),
        .crop_on(cfg_crop && !cfg_jpeg),                 // R8
        .x0(crop_x0), .xcnt(crop_xcnt), .y0(crop_y0), .ycnt(crop_ycnt),
        .in_win(in_win)
    );

    assign byte_vld = (state == ST_CAPTURE) && vs_act && hs_act && in_win;
    assign fe_evt   = (state == ST_CAPTURE) && vs_fall;

    cap_packer #(.OUT_W(OUT_W)) u_pack (
        .clk(clk), .rst_n(rst_n),
        .frame_start(vs_rise), .byte_vld(byte_vld), .byte_in(pix_data),
        .flush(fe_evt && cfg_jpeg), .drop(fe_evt && !cfg_jpeg),
        .clr_ovr(ctl_start),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .overrun(overrun)
    );

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_active |=> !$rose(out_valid));
endmodule

// File: tb/cam_capture_ctrl_test.sv
module cam_capture_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        hsync_in = 1'b0, vsync_in = 1'b0;
    logic        ctl_start = 1'b0, ctl_stop = 1'b0;
    logic        cfg_snapshot = 1'b0, cfg_jpeg = 1'b0, cfg_crop = 1'b0;
    logic        cfg_embedded = 1'b0, cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1;
    logic [11:0] crop_x0 = '0, crop_xcnt = '0, crop_y0 = '0, crop_ycnt = '0;
    logic [31:0] out_data;
    logic        out_valid, out_ready = 1'b1;
    logic        cap_active, frame_end, overrun, cfg_illegal;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_capture_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .cfg_snapshot(cfg_snapshot), .cfg_jpeg(cfg_jpeg), .cfg_crop(cfg_crop),
        .cfg_embedded(cfg_embedded), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .crop_x0(crop_x0), .crop_xcnt(crop_xcnt), .crop_y0(crop_y0), .crop_ycnt(crop_ycnt),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .cap_active(cap_active), .frame_end(frame_end), .overrun(overrun),
        .cfg_illegal(cfg_illegal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic phys(input bit act, input bit pol);
        return cfg_embedded ? act : (pol ? act : !act);
    endfunction

    task automatic lines_idle();
        hsync_in = phys(1'b0, cfg_hs_pol);
        vsync_in = phys(1'b0, cfg_vs_pol);
    endtask

    function automatic bit in_win(input int x, input int y);
        if (!cfg_crop || cfg_jpeg) return 1'b1;
        return x >= int'(crop_x0) && x < int'(crop_x0) + int'(crop_xcnt) &&
               y >= int'(crop_y0) && y < int'(crop_y0) + int'(crop_ycnt);
    endfunction

    // driver: sends one frame and pushes the words the requirements predict
    task automatic run_frame(input int nl, input int nb, input bit capt,
                             input int stop_line, input bit start_mid,
                             input bit only_first, input int fid);
        logic [31:0] acc = '0;
        int idx = 0;
        int pushed = 0;
        @(negedge clk); lines_idle();
        @(negedge clk); vsync_in = phys(1'b1, cfg_vs_pol);
        @(negedge clk);
        @(negedge clk);
        for (int y = 0; y < nl; y++) begin
            for (int x = 0; x < nb; x++) begin
                logic [7:0] v;
                @(negedge clk);
                v = 8'((fid * 37 + y * 13 + x * 5 + 1) & 255);
                hsync_in  = phys(1'b1, cfg_hs_pol);
                pix_data  = v;
                ctl_start = start_mid && y == 0 && x == 0;
                ctl_stop  = (y == stop_line) && x == 0;
                if (stop_line >= 0 && y == stop_line + 1 && x == 0)
                    chk(cap_active == 1'b1, "R5", "active after mid-frame stop", 32'(cap_active), 1);
                if (capt && in_win(x, y)) begin
                    acc |= 32'(v) << (8 * idx);
                    idx++;
                    if (idx == 4) begin
                        if (!only_first || pushed == 0) exp_q.push_back(acc);
                        pushed++;
                        acc = '0;
                        idx = 0;
                    end
                end
            end
            @(negedge clk);
            hsync_in = phys(1'b0, cfg_hs_pol);
            ctl_start = 1'b0; ctl_stop = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        vsync_in = phys(1'b0, cfg_vs_pol);
        if (capt && cfg_jpeg && idx != 0) exp_q.push_back(acc);
        @(negedge clk);
        chk(frame_end == capt, "R12", "frame_end after vsync drop", 32'(frame_end), 32'(capt));
        @(negedge clk);
        chk(frame_end == 1'b0, "R12", "frame_end one cycle", 32'(frame_end), 0);
    endtask

    task automatic pulse_start();
        @(negedge clk); ctl_start = 1'b1;
        @(negedge clk); ctl_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); ctl_stop = 1'b1;
        @(negedge clk); ctl_stop = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected words left", 32'(exp_q.size()), 0);
        exp_q.delete();
    endtask

    // monitor: pops and compares every accepted word
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R3", "unexpected word", out_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R3", "word value", out_data, e);
                end
            end
        end
    end

    bit done = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cap_active == 0, "R1", "cap_active", 32'(cap_active), 0);
        chk(out_valid == 0, "R1", "out_valid", 32'(out_valid), 0);
        chk(frame_end == 0 && overrun == 0, "R1", "frame_end|overrun",
            32'({frame_end, overrun}), 0);

        // R10 legality
        cfg_embedded = 1; cfg_jpeg = 1; #1;
        chk(cfg_illegal == 1, "R10", "embedded+jpeg", 32'(cfg_illegal), 1);
        cfg_jpeg = 0; #1;
        chk(cfg_illegal == 0, "R10", "embedded only", 32'(cfg_illegal), 0);
        cfg_embedded = 0;

        // R2: disabled frame, then enable mid-frame, then captured frame (R3)
        run_frame(2, 8, 0, -1, 0, 0, 1);
        run_frame(2, 8, 0, -1, 1, 0, 2);
        chk(cap_active == 1, "R2", "armed after start", 32'(cap_active), 1);
        run_frame(2, 8, 1, -1, 0, 0, 3);
        drain("R3");

        // R5: stop in the middle of a continuous frame
        run_frame(3, 4, 1, 1, 0, 0, 4);
        chk(cap_active == 0, "R5", "cleared at frame end", 32'(cap_active), 0);
        run_frame(1, 8, 0, -1, 0, 0, 5);
        drain("R5");

        // R6: stop while armed
        pulse_start();
        chk(cap_active == 1, "R6", "armed", 32'(cap_active), 1);
        pulse_stop();
        chk(cap_active == 0, "R6", "immediate disarm", 32'(cap_active), 0);

        // R4: snapshot
        cfg_snapshot = 1;
        pulse_start();
        run_frame(2, 4, 1, -1, 0, 0, 6);
        chk(cap_active == 0, "R4", "auto clear", 32'(cap_active), 0);
        run_frame(2, 4, 0, -1, 0, 0, 7);
        drain("R4");

        // R7: crop inside picture, then overhanging window
        cfg_crop = 1; crop_x0 = 2; crop_xcnt = 4; crop_y0 = 1; crop_ycnt = 2;
        pulse_start();
        run_frame(4, 8, 1, -1, 0, 0, 8);
        drain("R7");
        crop_x0 = 6; crop_xcnt = 8; crop_y0 = 2; crop_ycnt = 5;
        pulse_start();
        run_frame(4, 8, 1, -1, 0, 0, 9);
        drain("R7");

        // R8: jpeg ignores crop, flushes zero-filled partial word
        cfg_jpeg = 1; crop_x0 = 100;
        pulse_start();
        run_frame(1, 10, 1, -1, 0, 0, 10);
        drain("R8");
        // R8: non-jpeg partial word discarded, fresh word per frame
        cfg_jpeg = 0; cfg_crop = 0; cfg_snapshot = 0;
        pulse_start();
        run_frame(1, 6, 1, -1, 0, 0, 11);
        run_frame(1, 6, 1, -1, 0, 0, 12);
        pulse_stop();
        drain("R8");

        // R9: active-low lines, then embedded select ignoring polarity
        cfg_snapshot = 1; cfg_hs_pol = 0; cfg_vs_pol = 0;
        @(negedge clk); lines_idle();
        pulse_start();
        run_frame(2, 4, 1, -1, 0, 0, 13);
        drain("R9");
        cfg_embedded = 1;
        @(negedge clk); lines_idle();
        pulse_start();
        run_frame(2, 4, 1, -1, 0, 0, 14);
        drain("R9");
        cfg_embedded = 0; cfg_hs_pol = 1; cfg_vs_pol = 1;
        @(negedge clk); lines_idle();

        // R11: stalled sink, overrun
        out_ready = 0;
        pulse_start();
        run_frame(1, 12, 1, -1, 0, 1, 15);
        chk(overrun == 1, "R11", "overrun set", 32'(overrun), 1);
        chk(out_valid == 1 && exp_q.size() == 1 && out_data == exp_q[0], "R11",
            "held word", out_data, exp_q.size() > 0 ? exp_q[0] : 32'hX);
        @(negedge clk); out_ready = 1;
        drain("R11");
        chk(overrun == 1, "R11", "overrun sticky", 32'(overrun), 1);
        pulse_start();
        chk(overrun == 0, "R11", "cleared by start", 32'(overrun), 0);
        pulse_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule